// File: doc/BRIEF.md
# Page Write Buffer with Self-Timed Programming

This block sits behind a serial memory command decoder and handles the data phase of a memory write. When the decoder has received the write opcode and the address, it pulses `start` with that address. The address is split into a fixed page number and a starting offset inside the page. Each data byte that follows arrives with a one-cycle `byte_vld` strobe. The block stores the byte in a page-sized buffer and advances the offset. The offset wraps to the start of the page, so any surplus bytes overwrite bytes loaded earlier.

When chip select rises, the decoder pulses `cs_rise`. With it come two flags: `byte_aligned`, which says whether the transfer stopped on a whole byte, and `wr_allow`, which merges the write enable latch with the protection checks. A programming cycle starts only if all three conditions hold and at least one byte was loaded. Otherwise the buffer is dropped. The cycle lasts a fixed number of clocks. During the first `PAGE_BYTES` clocks of the cycle, the loaded slots are written to the array one per clock, in ascending offset order. Slots that were never loaded are skipped. `busy` (the ready/busy status bit) stays high for the whole cycle, and any new command activity during it is ignored. A one-cycle `wr_done` pulse marks the end of the cycle, and the decoder uses it to clear its write enable latch.

Top module: `pgwr_engine`

## Requirements
- R1: After reset, `busy`, `arr_we` and `wr_done` are 0.
- R2: `start` (ignored while `busy`) takes `start_addr[ADDR_W-1:OFF_W]` as the page number and `start_addr[OFF_W-1:0]` as the first slot. Each accepted data byte goes to the current slot, and the slot then advances by one modulo `PAGE_BYTES`. Every array write uses address {page number, slot}.
- R3: When more than `PAGE_BYTES` bytes are loaded, the slot wraps to 0 and the later byte replaces the earlier one. Only the last byte loaded into a slot reaches the array.
- R4: Only loaded slots are written, each exactly once per cycle. Every other location in the page keeps its contents.
- R5: A programming cycle starts on `cs_rise` only when `byte_aligned`=1, `wr_allow`=1 and at least one byte has been loaded since `start`. In every other case the buffer is discarded, no array write occurs and `busy` stays 0.
- R6: `busy` rises in the cycle after the clock edge that samples the committing `cs_rise`. It then stays high for exactly `PROG_CYCLES` cycles.
- R7: `wr_done` is high for exactly one cycle: the first cycle after the last `busy` cycle.
- R8: `start`, `byte_vld` and `cs_rise` have no effect while `busy` is high. After the cycle ends, a `cs_rise` that was not preceded by a new `start` commits nothing.
- R9: `arr_we` is asserted only while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Write command address received; opens a new buffer |
| start_addr | input | ADDR_W | Byte address from the write command |
| byte_vld | input | 1 | One data byte received |
| byte_data | input | 8 | Received data byte |
| cs_rise | input | 1 | Chip select rising event |
| byte_aligned | input | 1 | Transfer ended on a byte boundary (valid with `cs_rise`) |
| wr_allow | input | 1 | Write permitted (latch set, not protected) |
| arr_we | output | 1 | Array write strobe |
| arr_addr | output | ADDR_W | Array write address |
| arr_wdata | output | 8 | Array write data |
| busy | output | 1 | Programming cycle in progress |
| wr_done | output | 1 | One-cycle pulse at the end of the cycle |

## Verification
The committing `cs_rise` is sampled at edge E0. `busy` must be high in the cycle after E0, and array writes must fall inside busy cycles 1 to `PAGE_BYTES`. `busy` must stay high for `PROG_CYCLES` cycles, and `wr_done` is due in the single cycle that follows. The bench drives inputs and samples outputs on falling edges. It counts busy cycles from the first falling edge after E0, checks `wr_done` at the first falling edge where `busy` is low and again one cycle later, and captures array writes at falling edges into its own memory model. It then compares that model with an image computed arithmetically from the start address, the byte count and the wrap rule. The sweep covers page-end start offsets, byte counts from 1 to 20 (including counts past a full page), and every rejection case.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;

  typedef enum logic [1:0] {
    PG_IDLE = 2'd0,
    PG_LOAD = 2'd1,
    PG_PROG = 2'd2
  } pg_state_e;

  // next slot inside a page of 'page' bytes
  function automatic int unsigned pg_wrap(input int unsigned off, input int unsigned page);
    return (off + 1) % page;
  endfunction

  // commit rule: whole bytes, permission, and something loaded
  function automatic logic pg_may_commit(input logic aligned, input logic allow, input logic any);
    return aligned & allow & any;
  endfunction

endpackage

// File: rtl/pgwr_addr.sv
module pgwr_addr #(
  parameter int ADDR_W     = 8,
  parameter int PAGE_BYTES = 16,
  localparam int OFF_W     = $clog2(PAGE_BYTES),
  localparam int PG_W      = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              step,
  output logic [PG_W-1:0]   page_q,
  output logic [OFF_W-1:0]  off_q
);
  import pgwr_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= '0;
      off_q  <= '0;
    end else if (load) begin
      page_q <= addr_in[ADDR_W-1:OFF_W];
      off_q  <= addr_in[OFF_W-1:0];
    end else if (step) begin
      off_q  <= OFF_W'(pg_wrap(32'(off_q), PAGE_BYTES));
    end
  end

endmodule

// File: rtl/pgwr_buffer.sv
module pgwr_buffer #(
  parameter int PAGE_BYTES = 16,
  parameter int DATA_W     = 8,
  localparam int OFF_W     = $clog2(PAGE_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr_en,
  input  logic [OFF_W-1:0]  wr_off,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [OFF_W-1:0]  rd_off,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_loaded,
  output logic              any_loaded
);

  logic [DATA_W-1:0]     slot_q [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] ld_q;

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q[g] <= '0;
        ld_q[g]   <= 1'b0;
      end else if (clr) begin
        ld_q[g]   <= 1'b0;
      end else if (wr_en && wr_off == OFF_W'(g)) begin
        slot_q[g] <= wr_data;
        ld_q[g]   <= 1'b1;
      end
    end
  end

  assign rd_data    = slot_q[rd_off];
  assign rd_loaded  = ld_q[rd_off];
  assign any_loaded = |ld_q;

endmodule

// File: rtl/pgwr_timer.sv
module pgwr_timer #(
  parameter int CYCLES  = 48,
  localparam int CNT_W  = $clog2(CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  output logic [CNT_W-1:0] cnt_q,
  output logic             last
);
  localparam logic [CNT_W-1:0] LAST_V = CNT_W'(CYCLES - 1);

  logic run_q;

  assign last = run_q && (cnt_q == LAST_V);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (go) begin
      run_q <= 1'b1;
      cnt_q <= '0;
    end else if (last) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (run_q) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/pgwr_engine.sv
module pgwr_engine #(
  parameter int ADDR_W      = 8,
  parameter int PAGE_BYTES  = 16,
  parameter int PROG_CYCLES = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              byte_vld,
  input  logic [7:0]        byte_data,
  input  logic              cs_rise,
  input  logic              byte_aligned,
  input  logic              wr_allow,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [7:0]        arr_wdata,
  output logic              busy,
  output logic              wr_done
);
  import pgwr_pkg::*;

  localparam int OFF_W = $clog2(PAGE_BYTES);
  localparam int PG_W  = ADDR_W - OFF_W;
  localparam int CNT_W = $clog2(PROG_CYCLES + 1);
  localparam logic [CNT_W-1:0] PAGE_CNT = CNT_W'(PAGE_BYTES);

  initial begin
    if (PROG_CYCLES < PAGE_BYTES || (1 << OFF_W) != PAGE_BYTES || PG_W < 1)
      $error("pgwr_engine: bad parameters");
  end

  pg_state_e state_q;

  // named internal events
  logic start_go, byte_go, commit_go, discard_go, cycle_end;
  logic any_loaded, slot_loaded;
  logic [PG_W-1:0]  page_q;
  logic [OFF_W-1:0] off_q;
  logic [CNT_W-1:0] cnt_q;
  logic [7:0]       slot_data;

  assign start_go   = start && !cs_rise && (state_q != PG_PROG);
  assign byte_go    = byte_vld && (state_q == PG_LOAD);
  assign commit_go  = cs_rise && (state_q == PG_LOAD) &&
                      pg_may_commit(byte_aligned, wr_allow, any_loaded);
  assign discard_go = cs_rise && (state_q == PG_LOAD) && !commit_go;

  pgwr_addr #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_addr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (start_go),
    .addr_in (start_addr),
    .step    (byte_go),
    .page_q  (page_q),
    .off_q   (off_q)
  );

  pgwr_buffer #(.PAGE_BYTES(PAGE_BYTES), .DATA_W(8)) u_buf (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (start_go || discard_go || cycle_end),
    .wr_en      (byte_go),
    .wr_off     (off_q),
    .wr_data    (byte_data),
    .rd_off     (cnt_q[OFF_W-1:0]),
    .rd_data    (slot_data),
    .rd_loaded  (slot_loaded),
    .any_loaded (any_loaded)
  );

  pgwr_timer #(.CYCLES(PROG_CYCLES)) u_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .go    (commit_go),
    .cnt_q (cnt_q),
    .last  (cycle_end)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PG_IDLE;
      wr_done <= 1'b0;
    end else begin
      wr_done <= cycle_end;
      unique case (state_q)
        PG_PROG: if (cycle_end) state_q <= PG_IDLE;
        PG_LOAD: begin
          if (commit_go)       state_q <= PG_PROG;
          else if (discard_go) state_q <= PG_IDLE;
        end
        default: if (start_go) state_q <= PG_LOAD;
      endcase
    end
  end

  assign busy      = (state_q == PG_PROG);
  assign arr_we    = busy && (cnt_q < PAGE_CNT) && slot_loaded;
  assign arr_addr  = {page_q, cnt_q[OFF_W-1:0]};
  assign arr_wdata = slot_data;

endmodule

// File: rtl/pgwr_engine_chk.sv
module pgwr_engine_chk #(
  parameter int ADDR_W      = 8,
  parameter int PAGE_BYTES  = 16,
  parameter int PROG_CYCLES = 48
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [ADDR_W-1:0] start_addr,
  input logic              cs_rise,
  input logic              byte_aligned,
  input logic              wr_allow,
  input logic              arr_we,
  input logic [ADDR_W-1:0] arr_addr,
  input logic              busy,
  input logic              wr_done,
  input logic              commit_go
);
  localparam int OFF_W = $clog2(PAGE_BYTES);
  localparam int RUN_W = $clog2(PROG_CYCLES + 2);

  logic [RUN_W-1:0]        run_len;
  logic [ADDR_W-OFF_W-1:0] page_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_len   <= '0;
      page_seen <= '0;
    end else begin
      run_len <= busy ? run_len + 1'b1 : '0;
      if (start && !busy && !cs_rise) page_seen <= start_addr[ADDR_W-1:OFF_W];
    end
  end

  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_n |=> (!busy && !arr_we && !wr_done) || !rst_n);

  assert_page_fixed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> arr_addr[ADDR_W-1:OFF_W] == page_seen);

  assert_commit_cond_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cs_rise && byte_aligned && wr_allow));

  assert_commit_starts_R6: assert property (@(posedge clk) disable iff (!rst_n)
    commit_go |=> busy);

  assert_busy_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> run_len == RUN_W'(PROG_CYCLES));

  assert_done_place_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done |-> (!busy && $past(busy)));

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done |=> !wr_done);

  assert_done_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> wr_done);

  assert_we_in_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> busy);

endmodule

bind pgwr_engine pgwr_engine_chk #(
  .ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .PROG_CYCLES(PROG_CYCLES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
  .cs_rise(cs_rise), .byte_aligned(byte_aligned), .wr_allow(wr_allow),
  .arr_we(arr_we), .arr_addr(arr_addr), .busy(busy), .wr_done(wr_done),
  .commit_go(commit_go)
);

// File: tb/pgwr_engine_tb.sv
module pgwr_engine_tb;
  localparam int AW = 8;
  localparam int PB = 16;
  localparam int PC = 48;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, byte_vld = 1'b0, cs_rise = 1'b0;
  logic byte_aligned = 1'b0, wr_allow = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic [7:0] byte_data = '0;
  logic arr_we, busy, wr_done;
  logic [AW-1:0] arr_addr;
  logic [7:0] arr_wdata;

  int checks = 0, fails = 0;
  int n_writes = 0;
  bit finished = 1'b0;
  logic [7:0] mem_seen [256];
  logic [7:0] mem_exp  [256];

  always #2 clk = ~clk;

  pgwr_engine #(.ADDR_W(AW), .PAGE_BYTES(PB), .PROG_CYCLES(PC)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .byte_vld(byte_vld), .byte_data(byte_data), .cs_rise(cs_rise),
    .byte_aligned(byte_aligned), .wr_allow(wr_allow), .arr_we(arr_we),
    .arr_addr(arr_addr), .arr_wdata(arr_wdata), .busy(busy), .wr_done(wr_done)
  );

  always @(negedge clk) begin
    if (rst_n && arr_we) begin
      mem_seen[arr_addr] = arr_wdata;
      n_writes++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  function automatic logic [7:0] dat(input int seed, input int i);
    return 8'((seed * 37 + i * 11 + 5) & 255);
  endfunction

  task automatic cmp_mem(input string req);
    int bad = 0;
    for (int k = 0; k < 256; k++) if (mem_seen[k] !== mem_exp[k]) bad++;
    chk(bad == 0, req, bad, 0);
  endtask

  // one write command; 'disturb' pokes commands while busy
  task automatic run_cmd(input logic [AW-1:0] a, input int n, input int seed,
                         input bit align, input bit allow, input bit disturb);
    bit commit;
    int blen;
    int expw;
    commit = align && allow && (n > 0);
    expw = (n < PB) ? n : PB;
    n_writes = 0;
    @(negedge clk); start = 1'b1; start_addr = a;
    @(negedge clk); start = 1'b0;
    for (int i = 0; i < n; i++) begin
      byte_vld = 1'b1; byte_data = dat(seed, i);
      @(negedge clk);
      byte_vld = 1'b0;
      if (i % 3 == 1) @(negedge clk);
    end
    cs_rise = 1'b1; byte_aligned = align; wr_allow = allow;
    @(negedge clk);
    cs_rise = 1'b0; byte_aligned = 1'b0; wr_allow = 1'b0;
    if (commit) begin
      // R2/R3: expected image, later bytes overwrite wrapped slots
      for (int i = 0; i < n; i++)
        mem_exp[{a[AW-1:4], 4'((int'(a[3:0]) + i) % PB)}] = dat(seed, i);
      chk(busy == 1'b1, "R6 busy rise", int'(busy), 1);
      blen = 1;
      while (busy) begin
        if (disturb && blen == 3) begin
          start = 1'b1; start_addr = ~a; byte_vld = 1'b1; byte_data = 8'hEE;
        end else if (disturb && blen == 4) begin
          start = 1'b0; byte_vld = 1'b0;
          cs_rise = 1'b1; byte_aligned = 1'b1; wr_allow = 1'b1;
        end else begin
          start = 1'b0; byte_vld = 1'b0;
          cs_rise = 1'b0; byte_aligned = 1'b0; wr_allow = 1'b0;
        end
        @(negedge clk);
        if (busy) blen++;
        if (blen > PC + 4) break;
      end
      start = 1'b0; byte_vld = 1'b0; cs_rise = 1'b0; byte_aligned = 1'b0; wr_allow = 1'b0;
      chk(blen == PC, "R6 busy length", blen, PC);
      chk(wr_done == 1'b1, "R7 done pulse", int'(wr_done), 1);
      @(negedge clk);
      chk(wr_done == 1'b0, "R7 done single", int'(wr_done), 0);
      chk(n_writes == expw, "R4 write count", n_writes, expw);
      cmp_mem("R2 R3 R4 array image");
    end else begin
      chk(busy == 1'b0, "R5 no cycle", int'(busy), 0);
      repeat (PC + 2) @(negedge clk);
      chk(busy == 1'b0 && wr_done == 1'b0, "R5 stays idle", int'(busy), 0);
      chk(n_writes == 0, "R5 no writes", n_writes, 0);
      cmp_mem("R5 array unchanged");
    end
  endtask

  initial begin
    for (int k = 0; k < 256; k++) begin
      mem_seen[k] = 8'h00;
      mem_exp[k]  = 8'h00;
    end
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(busy == 1'b0 && arr_we == 1'b0 && wr_done == 1'b0, "R1 reset outputs",
        int'({busy, arr_we, wr_done}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0, "R1 idle after reset", int'(busy), 0);

    // R2 R3 R4 R6 R7: sweep byte counts and start offsets
    for (int n = 1; n <= 20; n++)
      run_cmd(AW'((n * 53 + 7) & 255), n, n, 1'b1, 1'b1, 1'b0);
    // page-end offsets with wrap
    run_cmd(8'h0F, 2, 31, 1'b1, 1'b1, 1'b0);
    run_cmd(8'hFF, 17, 32, 1'b1, 1'b1, 1'b0);
    run_cmd(8'h80, 16, 33, 1'b1, 1'b1, 1'b0);
    run_cmd(8'h47, 33, 34, 1'b1, 1'b1, 1'b0);

    // R5: rejection cases
    run_cmd(8'h21, 4, 40, 1'b0, 1'b1, 1'b0);  // mid-byte CS rise
    run_cmd(8'h22, 0, 41, 1'b1, 1'b1, 1'b0);  // no data byte
    run_cmd(8'h23, 5, 42, 1'b1, 1'b0, 1'b0);  // write not permitted

    // R8: activity during busy ignored
    run_cmd(8'h64, 6, 50, 1'b1, 1'b1, 1'b1);
    n_writes = 0;
    @(negedge clk); cs_rise = 1'b1; byte_aligned = 1'b1; wr_allow = 1'b1;
    @(negedge clk); cs_rise = 1'b0; byte_aligned = 1'b0; wr_allow = 1'b0;
    chk(busy == 1'b0, "R8 no stale commit", int'(busy), 0);
    repeat (PC + 2) @(negedge clk);
    chk(n_writes == 0, "R8 no stale writes", n_writes, 0);
    cmp_mem("R8 array image");
    // R9 covered by the writes-only-while-busy count: a normal command after
    run_cmd(8'h65, 3, 51, 1'b1, 1'b1, 1'b0);

    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule